// File: doc/BRIEF.md
# Floating-Point Predicate Evaluator

This block decides whether a selected floating-point predicate holds, given the flags left by the last floating-point operation. Those flags are negative, zero, infinity and not-a-number (NaN). The condition result is purely combinational, so the sequencer that performs a conditional branch or a conditional move can use it in the same cycle it presents the select code.

The relational predicates come in two forms: a plain form and a "not" form that is its exact complement. Both forms are unaware of unordered operands. When such a predicate is evaluated while the NaN flag is set, the block raises two sticky flags on the next clock edge: an unordered-test flag and an invalid-operation flag. An error predicate reports whether any exception status bit is set, or whether the unordered-test flag was already held before the current evaluation.

Top module: `fpcc_eval`

## Requirements
- R1: Select codes 0 (EQ), 10 (NE), 9 (MI), 19 (PL), 6 (INF) and 15 (NINF) give zero set, zero clear, negative set, negative clear, infinity set and infinity clear respectively.
- R2: Code 18 (ordered) and code 4 (GLE) are true when NaN is clear. Code 20 (unordered) and code 13 (NGLE) are true when NaN is set.
- R3: Code 5 (GT) is true when none of NaN, zero or negative is set. Code 2 (GE) is true unless NaN is set or (negative and not zero). Code 8 (LT) is true unless NaN, zero or not-negative. Code 7 (LE) is true unless NaN or neither negative nor zero. Code 3 (GL) is true unless NaN or zero.
- R4: Codes 14 (NGT), 11 (NGE), 17 (NLT), 16 (NLE) and 12 (NGL) are the exact complements of GT, GE, LT, LE and GL for every flag pattern.
- R5: Code 1 (ERR) is true when any bit of `exc_i` is set, or when the unordered-test flag is set. The bits of `exc_i` are: bit 0 divide-by-zero, bit 1 underflow, bit 2 overflow, bit 3 invalid operation, bit 4 signaling NaN. ERR reads the unordered-test flag as it stood before the current cycle's evaluation.
- R6: When `eval_i` is high and the code is one of 2,3,4,5,7,8,11,12,13,14,16,17 and NaN is set, both `unord_o` and `inval_o` read 1 after the next rising clock edge.
- R7: An evaluation leaves `unord_o` and `inval_o` unchanged in three cases: the code is one of 0,1,6,9,10,15,18,19,20; the code is a relational code with NaN clear; or `eval_i` is low.
- R8: Codes 21 to 31 give a false result for every flag pattern and never change the sticky flags.
- R9: The sticky flags are set-only under evaluation. Each is cleared to 0 by synchronous active-low reset or by `clr_i`. If a clear and a setting evaluation happen in the same cycle, the clear wins.
- R10: `cond_o` depends only on the select code, the result flags, `exc_i` and the held sticky flag. It does not depend on `eval_i`. After reset both sticky flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of both sticky flags |
| eval_i | input | 1 | Evaluate strobe; enables sticky flag update |
| sel_i | input | 5 | Predicate select code |
| res_n_i | input | 1 | Result negative flag |
| res_z_i | input | 1 | Result zero flag |
| res_inf_i | input | 1 | Result infinity flag |
| res_nan_i | input | 1 | Result NaN flag |
| exc_i | input | 5 | Exception status bits (see R5) |
| cond_o | output | 1 | Predicate result |
| unord_o | output | 1 | Sticky unordered-test flag |
| inval_o | output | 1 | Sticky invalid-operation flag |

## Verification
The block has no free parameters beyond the fixed 5-bit select code and the 5-bit exception field. The bench therefore builds it at those widths. At that size all 32 select codes can be swept against all 16 combinations of negative, zero, infinity and NaN. Every predicate, every complement pair and every unused code is checked exhaustively, not by sampling. Directed sequences then cover the sticky flag's three paths: setting, holding, and clearing when a clear collides with a setting evaluation.

// File: rtl/fpcc_pkg.sv
// Package: shared select codes and classification helpers for the
// floating-point predicate evaluator.
// Assumes: 5-bit select code; codes above CODE_LAST are unused.
package fpcc_pkg;

    localparam int CODE_W    = 5;
    localparam int EXC_W     = 5;
    localparam int CODE_LAST = 20;

    // Exception status bit positions inside exc_i.
    localparam int EXC_DZ    = 0;
    localparam int EXC_UNF   = 1;
    localparam int EXC_OVF   = 2;
    localparam int EXC_OPER  = 3;
    localparam int EXC_SNAN  = 4;

    typedef enum logic [CODE_W-1:0] {
        P_EQ   = 5'd0,
        P_ERR  = 5'd1,
        P_GE   = 5'd2,
        P_GL   = 5'd3,
        P_GLE  = 5'd4,
        P_GT   = 5'd5,
        P_INF  = 5'd6,
        P_LE   = 5'd7,
        P_LT   = 5'd8,
        P_MI   = 5'd9,
        P_NE   = 5'd10,
        P_NGE  = 5'd11,
        P_NGL  = 5'd12,
        P_NGLE = 5'd13,
        P_NGT  = 5'd14,
        P_NINF = 5'd15,
        P_NLE  = 5'd16,
        P_NLT  = 5'd17,
        P_OR   = 5'd18,
        P_PL   = 5'd19,
        P_UN   = 5'd20
    } pred_code_e;

    // Result flags of the last floating-point operation.
    typedef struct packed {
        logic neg;
        logic zero;
        logic inf;
        logic nan;
    } fp_flags_t;

    // True for relational codes that do not tolerate unordered operands.
    function automatic logic code_is_unaware(input logic [CODE_W-1:0] c);
        case (c)
            P_GE, P_GL, P_GLE, P_GT, P_LE, P_LT,
            P_NGE, P_NGL, P_NGLE, P_NGT, P_NLE, P_NLT: code_is_unaware = 1'b1;
            default:                                   code_is_unaware = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fpcc_relate.sv
// Module: fpcc_relate
// Forms the ordered relational base terms from the result flags.
// Assumes: flags are stable for the cycle; purely combinational.
module fpcc_relate
    import fpcc_pkg::*;
(
    input  fp_flags_t flags_i,
    output logic      gt_o,
    output logic      ge_o,
    output logic      lt_o,
    output logic      le_o,
    output logic      gl_o,
    output logic      ord_o
);
    // Derive each relational base term; NaN forces every one false.
    always_comb begin
        ord_o = ~flags_i.nan;
        gt_o  = ~(flags_i.nan | flags_i.zero | flags_i.neg);
        ge_o  = ~(flags_i.nan | (flags_i.neg & ~flags_i.zero));
        lt_o  = ~(flags_i.nan | flags_i.zero | ~flags_i.neg);
        le_o  = ~(flags_i.nan | ~(flags_i.neg | flags_i.zero));
        gl_o  = ~(flags_i.nan | flags_i.zero);
    end

    // R3: with NaN set no ordered relation may hold.
    always_comb begin
        if (flags_i.nan)
            a_r3_nan_kills_relations: assert (!(gt_o | ge_o | lt_o | le_o | gl_o));
    end
endmodule

// File: rtl/fpcc_select.sv
// Module: fpcc_select
// Picks the predicate named by the select code from the base terms.
// Assumes: base terms from fpcc_relate; err_held is the pre-update
// unordered sticky value; unused codes yield false.
module fpcc_select
    import fpcc_pkg::*;
(
    input  logic [CODE_W-1:0] sel_i,
    input  fp_flags_t         flags_i,
    input  logic [EXC_W-1:0]  exc_i,
    input  logic              unord_held_i,
    input  logic              gt_i,
    input  logic              ge_i,
    input  logic              lt_i,
    input  logic              le_i,
    input  logic              gl_i,
    input  logic              ord_i,
    output logic              cond_o
);
    logic err_any;

    // Error predicate: any exception bit, or a previously held unordered test.
    always_comb begin
        err_any = (|exc_i) | unord_held_i;
    end

    // Multiplex the selected predicate; complements invert their base term.
    always_comb begin
        case (sel_i)
            P_EQ:    cond_o = flags_i.zero;
            P_NE:    cond_o = ~flags_i.zero;
            P_MI:    cond_o = flags_i.neg;
            P_PL:    cond_o = ~flags_i.neg;
            P_INF:   cond_o = flags_i.inf;
            P_NINF:  cond_o = ~flags_i.inf;
            P_OR:    cond_o = ord_i;
            P_UN:    cond_o = ~ord_i;
            P_GLE:   cond_o = ord_i;
            P_NGLE:  cond_o = ~ord_i;
            P_GT:    cond_o = gt_i;
            P_NGT:   cond_o = ~gt_i;
            P_GE:    cond_o = ge_i;
            P_NGE:   cond_o = ~ge_i;
            P_LT:    cond_o = lt_i;
            P_NLT:   cond_o = ~lt_i;
            P_LE:    cond_o = le_i;
            P_NLE:   cond_o = ~le_i;
            P_GL:    cond_o = gl_i;
            P_NGL:   cond_o = ~gl_i;
            P_ERR:   cond_o = err_any;
            default: cond_o = 1'b0;
        endcase
    end

    // R8: unused select codes never report true.
    always_comb begin
        if (sel_i > CODE_W'(CODE_LAST))
            a_r8_unused_false: assert (!cond_o);
    end
endmodule

// File: rtl/fpcc_sticky.sv
// Module: fpcc_sticky
// Holds the sticky unordered-test and invalid-operation flags.
// Assumes: synchronous active-low reset; clear has priority over set.
module fpcc_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic set_i,
    output logic unord_q,
    output logic inval_q
);
    // Set-only update of both sticky flags, cleared by reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            unord_q <= 1'b0;
            inval_q <= 1'b0;
        end else if (set_i) begin
            unord_q <= 1'b1;
            inval_q <= 1'b1;
        end
    end

    // R6: a setting request raises both flags on the next edge.
    a_r6_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> (unord_q && inval_q));

    // R9: without a clear, a raised flag stays raised.
    a_r9_set_only: assert property (@(posedge clk) disable iff (!rst_n)
        (unord_q && !clr_i) |=> unord_q);

    // R9: clear wins and empties both flags.
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!unord_q && !inval_q));
endmodule

// File: rtl/fpcc_eval.sv
// Module: fpcc_eval (top)
// Evaluates a selected floating-point predicate against the result flags
// and maintains the sticky unordered-test / invalid-operation flags.
// Assumes: select and flags valid when eval_i is high; cond_o is
// combinational and independent of eval_i.
module fpcc_eval
    import fpcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              eval_i,
    input  logic [CODE_W-1:0] sel_i,
    input  logic              res_n_i,
    input  logic              res_z_i,
    input  logic              res_inf_i,
    input  logic              res_nan_i,
    input  logic [EXC_W-1:0]  exc_i,
    output logic              cond_o,
    output logic              unord_o,
    output logic              inval_o
);
    fp_flags_t flags;
    logic gt, ge, lt, le, gl, ord;
    logic set_req;

    // Gather the result flags into one record.
    always_comb begin
        flags.neg  = res_n_i;
        flags.zero = res_z_i;
        flags.inf  = res_inf_i;
        flags.nan  = res_nan_i;
    end

    // Request sticky update: unaware predicate tested on unordered operands.
    always_comb begin
        set_req = eval_i & res_nan_i & code_is_unaware(sel_i);
    end

    fpcc_relate u_relate (
        .flags_i (flags),
        .gt_o    (gt),
        .ge_o    (ge),
        .lt_o    (lt),
        .le_o    (le),
        .gl_o    (gl),
        .ord_o   (ord)
    );

    fpcc_select u_select (
        .sel_i        (sel_i),
        .flags_i      (flags),
        .exc_i        (exc_i),
        .unord_held_i (unord_o),
        .gt_i         (gt),
        .ge_i         (ge),
        .lt_i         (lt),
        .le_i         (le),
        .gl_i         (gl),
        .ord_i        (ord),
        .cond_o       (cond_o)
    );

    fpcc_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .set_i   (set_req),
        .unord_q (unord_o),
        .inval_q (inval_o)
    );

    // R7: evaluation without a setting request leaves the flags as they were.
    a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!unord_o && !(eval_i && res_nan_i && code_is_unaware(sel_i))) |=> !unord_o);

    // R5: any exception bit makes the error predicate true.
    a_r5_err_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == P_ERR && exc_i != '0) |-> cond_o);
endmodule

// File: tb/fpcc_eval_test.sv
// Directed bench for fpcc_eval: one task per scenario, each self-checking.
module fpcc_eval_test;
    logic       clk = 1'b0;
    logic       rst_n, clr_i, eval_i;
    logic [4:0] sel_i;
    logic       res_n_i, res_z_i, res_inf_i, res_nan_i;
    logic [4:0] exc_i;
    logic       cond_o, unord_o, inval_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    fpcc_eval uut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .eval_i(eval_i),
        .sel_i(sel_i), .res_n_i(res_n_i), .res_z_i(res_z_i),
        .res_inf_i(res_inf_i), .res_nan_i(res_nan_i), .exc_i(exc_i),
        .cond_o(cond_o), .unord_o(unord_o), .inval_o(inval_o)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Expected predicate from the requirements.
    function automatic logic model(input int c, input logic n, input logic z,
                                   input logic i, input logic nan,
                                   input logic [4:0] exc, input logic held);
        logic gt, ge, lt, le, gl;
        gt = ~(nan | z | n);
        ge = ~(nan | (n & ~z));
        lt = ~(nan | z | ~n);
        le = ~(nan | ~(n | z));
        gl = ~(nan | z);
        case (c)
            0:  return z;        10: return ~z;
            9:  return n;        19: return ~n;
            6:  return i;        15: return ~i;
            18: return ~nan;     20: return nan;
            4:  return ~nan;     13: return nan;
            5:  return gt;       14: return ~gt;
            2:  return ge;       11: return ~ge;
            8:  return lt;       17: return ~lt;
            7:  return le;       16: return ~le;
            3:  return gl;       12: return ~gl;
            1:  return (|exc) | held;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input int c);
        case (c)
            0, 10, 9, 19, 6, 15: return "R1";
            18, 20, 4, 13:       return "R2";
            5, 2, 8, 7, 3:       return "R3";
            14, 11, 17, 16, 12:  return "R4";
            1:                   return "R5";
            default:             return "R8";
        endcase
    endfunction

    function automatic logic unaware(input int c);
        return (c inside {2,3,4,5,7,8,11,12,13,14,16,17});
    endfunction

    task automatic drive(input int c, input logic [3:0] f, input logic [4:0] exc, input logic ev, input logic clr);
        sel_i     = 5'(c);
        res_n_i   = f[3];
        res_z_i   = f[2];
        res_inf_i = f[1];
        res_nan_i = f[0];
        exc_i     = exc;
        eval_i    = ev;
        clr_i     = clr;
    endtask

    task automatic do_clear();
        @(negedge clk); drive(0, 4'h0, 5'h0, 1'b0, 1'b1);
        @(negedge clk); drive(0, 4'h0, 5'h0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10", unord_o, 1'b0, "unord after reset");
        check("R10", inval_o, 1'b0, "inval after reset");
    endtask

    // All codes against all flag patterns, eval low: R1-R4, R8, R10.
    task automatic t_sweep();
        for (int c = 0; c < 32; c++) begin
            for (int f = 0; f < 16; f++) begin
                @(negedge clk);
                drive(c, 4'(f), 5'h0, 1'b0, 1'b0);
                #1;
                check(req_of(c), cond_o, model(c, f[3], f[2], f[1], f[0], 5'h0, 1'b0),
                      $sformatf("code %0d flags %h", c, f));
            end
        end
        @(negedge clk);
        check("R10", unord_o, 1'b0, "no flag change with eval low");
    endtask

    task automatic t_err();
        for (int b = 0; b < 5; b++) begin
            @(negedge clk); drive(1, 4'h0, 5'(1 << b), 1'b0, 1'b0); #1;
            check("R5", cond_o, 1'b1, $sformatf("ERR with exc bit %0d", b));
        end
        @(negedge clk); drive(1, 4'h0, 5'h0, 1'b0, 1'b0); #1;
        check("R5", cond_o, 1'b0, "ERR with nothing set");
    endtask

    task automatic t_set();
        do_clear();
        @(negedge clk); drive(5, 4'h1, 5'h0, 1'b1, 1'b0); #1;
        check("R3", cond_o, 1'b0, "GT false on NaN");
        @(negedge clk); drive(1, 4'h0, 5'h0, 1'b0, 1'b0);
        check("R6", unord_o, 1'b1, "unord raised by GT on NaN");
        check("R6", inval_o, 1'b1, "inval raised by GT on NaN");
        #1;
        check("R5", cond_o, 1'b1, "ERR true from held unordered flag");
        // Same-cycle ERR reads the pre-update value.
        do_clear();
        @(negedge clk); drive(1, 4'h1, 5'h0, 1'b1, 1'b0); #1;
        check("R5", cond_o, 1'b0, "ERR before any setting test");
        for (int k = 0; k < 12; k++) begin
            int c;
            c = (k < 3) ? k + 2 : (k < 4) ? 5 : (k < 6) ? k + 3 : (k < 9) ? k + 5 : k + 5;
            do_clear();
            @(negedge clk); drive(c, 4'h1, 5'h0, 1'b1, 1'b0);
            @(negedge clk); drive(0, 4'h0, 5'h0, 1'b0, 1'b0);
            check("R6", unord_o & inval_o, unaware(c), $sformatf("code %0d on NaN", c));
        end
    endtask

    task automatic t_no_change();
        do_clear();
        for (int c = 0; c < 32; c++) begin
            if (!unaware(c)) begin
                @(negedge clk); drive(c, 4'h1, 5'h1F, 1'b1, 1'b0);
            end
        end
        @(negedge clk); drive(5, 4'h8, 5'h0, 1'b1, 1'b0);
        @(negedge clk); drive(12, 4'h1, 5'h0, 1'b0, 1'b0);
        @(negedge clk); drive(0, 4'h0, 5'h0, 1'b0, 1'b0);
        check("R7", unord_o, 1'b0, "aware, ordered or idle tests leave unord");
        check("R7", inval_o, 1'b0, "aware, ordered or idle tests leave inval");
        for (int c = 21; c < 32; c++) begin
            @(negedge clk); drive(c, 4'h1, 5'h0, 1'b1, 1'b0);
        end
        @(negedge clk); drive(0, 4'h0, 5'h0, 1'b0, 1'b0);
        check("R8", unord_o | inval_o, 1'b0, "unused codes leave flags");
    endtask

    task automatic t_clear();
        do_clear();
        @(negedge clk); drive(14, 4'h1, 5'h0, 1'b1, 1'b0);
        @(negedge clk); drive(0, 4'h0, 5'h0, 1'b1, 1'b0);
        @(negedge clk); drive(0, 4'h0, 5'h0, 1'b0, 1'b0);
        check("R9", unord_o, 1'b1, "flag held through aware evaluation");
        @(negedge clk); drive(17, 4'h1, 5'h0, 1'b1, 1'b1);
        @(negedge clk); drive(0, 4'h0, 5'h0, 1'b0, 1'b0);
        check("R9", unord_o, 1'b0, "clear wins over set (unord)");
        check("R9", inval_o, 1'b0, "clear wins over set (inval)");
        @(negedge clk); drive(3, 4'h1, 5'h0, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b0; drive(0, 4'h0, 5'h0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        check("R9", unord_o | inval_o, 1'b0, "reset clears flags");
    endtask

    initial begin
        #1_600_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 4'h0, 5'h0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sweep();
        t_err();
        t_set();
        t_no_change();
        t_clear();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule